// File: doc/BRIEF.md
# GPIO Port with Pin Interrupts

This block is one 32-pin general-purpose I/O port reached through a plain word-addressed register interface with an address, a write strobe, write data and combinational read data. It keeps an output latch and a direction vector. Both can be changed bit by bit without a read-modify-write, because write-one-only set, clear and toggle locations exist for them. The pad side is modelled as three plain vectors: sampled input, output level and output enable.

Every pin also feeds an interrupt detector. A mode bit chooses edge or level sensing, and a polarity bit chooses the active direction. Detections go into a status register that software clears by writing ones. An enable mask then reduces the status to one registered request line. Pin inputs pass through a two-flop synchronizer before anything else uses them. A pin's global index maps to port number index/32 and bit position index%32. This block is a single such port.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset the output latch, direction, interrupt mode, polarity, enable and status are all zero, so pad_oe is 0, pad_out is 0 and irq is 0.
- R2: A write to word 0 sets every latch bit written as 1. A write to word 1 clears every latch bit written as 1. A write to word 2 inverts every latch bit written as 1. Bits written as 0 are unchanged. pad_out shows the latch.
- R3: A write to word 3 makes every pin written as 1 an output (pad_oe bit 1). A write to word 4 makes every pin written as 1 an input. Bits written as 0 are unchanged.
- R4: The latch keeps its value while a pin is an input, so a pin that is turned back to output drives its last latched level.
- R5: Reading word 0 returns the output latch and reading word 3 returns the direction vector.
- R6: Reading word 5 returns the synchronized pad_in vector. Reading word 32+n returns pin n's synchronized level in bit 0, with all other bits zero. The result follows pad_in two clocks after a change, whatever the pin's direction.
- R7: Interrupt mode is word 6, where bit 1 means edge and bit 0 means level. Polarity is word 7, where bit 0 means rising/high and bit 1 means falling/low. In edge mode a status bit is set once per transition in the selected direction, and transitions in the other direction are ignored.
- R8: In level mode the status bit is set on every clock while the selected level is present, so a clear written during that time has no lasting effect.
- R9: Status is word 8. Writing 1 clears a bit and writing 0 leaves it unchanged. When a detection and a clear hit the same bit in one cycle, the detection wins.
- R10: Enable is word 9. irq is the OR of status AND enable, registered once.
- R11: Words 6, 7 and 9 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Raw pin levels |
| pad_out | output | 32 | Output latch to pads |
| pad_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Two events can land on the same status bit in the same cycle: a level-mode detection and a software write-one clear. The bench holds a pin at its active level and writes a clear to that bit, then reads status back at once. The bit must still read 1, which shows that the detection takes priority. A second case clears one of two pending edge bits, and the untouched bit must survive.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned ADDR_W  = 6;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned SYNC_FF = 2;

    localparam logic [ADDR_W-1:0] W_OUT_SET  = 6'd0;
    localparam logic [ADDR_W-1:0] W_OUT_CLR  = 6'd1;
    localparam logic [ADDR_W-1:0] W_OUT_TGL  = 6'd2;
    localparam logic [ADDR_W-1:0] W_DIR_SET  = 6'd3;
    localparam logic [ADDR_W-1:0] W_DIR_CLR  = 6'd4;
    localparam logic [ADDR_W-1:0] W_PIN_WORD = 6'd5;
    localparam logic [ADDR_W-1:0] W_IRQ_MODE = 6'd6;
    localparam logic [ADDR_W-1:0] W_IRQ_POL  = 6'd7;
    localparam logic [ADDR_W-1:0] W_IRQ_STAT = 6'd8;
    localparam logic [ADDR_W-1:0] W_IRQ_EN   = 6'd9;
    localparam logic [ADDR_W-1:0] W_PIN_BASE = 6'd32;

    typedef struct packed {
        logic out_set;
        logic out_clr;
        logic out_tgl;
        logic dir_set;
        logic dir_clr;
        logic mode_wr;
        logic pol_wr;
        logic stat_clr;
        logic en_wr;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s.out_set  = we && (a == W_OUT_SET);
        s.out_clr  = we && (a == W_OUT_CLR);
        s.out_tgl  = we && (a == W_OUT_TGL);
        s.dir_set  = we && (a == W_DIR_SET);
        s.dir_clr  = we && (a == W_DIR_CLR);
        s.mode_wr  = we && (a == W_IRQ_MODE);
        s.pol_wr   = we && (a == W_IRQ_POL);
        s.stat_clr = we && (a == W_IRQ_STAT);
        s.en_wr    = we && (a == W_IRQ_EN);
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  wr_strobe_t      stb,
    input  logic [NPIN-1:0] wd,
    output logic [NPIN-1:0] out_q,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] mode_q,
    output logic [NPIN-1:0] pol_q,
    output logic [NPIN-1:0] en_q
);
    logic [NPIN-1:0] out_n, dir_n;

    always_comb begin
        out_n = out_q;
        if (stb.out_set) out_n = out_q | wd;
        if (stb.out_clr) out_n = out_q & ~wd;
        if (stb.out_tgl) out_n = out_q ^ wd;
        dir_n = dir_q;
        if (stb.dir_set) dir_n = dir_q | wd;
        if (stb.dir_clr) dir_n = dir_q & ~wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
        end else begin
            out_q <= out_n;
            dir_q <= dir_n;
            if (stb.mode_wr) mode_q <= wd;
            if (stb.pol_wr)  pol_q  <= wd;
            if (stb.en_wr)   en_q   <= wd;
        end
    end
endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq #(
    parameter int unsigned NPIN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] lvl,
    input  logic [NPIN-1:0] edge_sel,
    input  logic [NPIN-1:0] low_sel,
    input  logic [NPIN-1:0] en,
    input  logic            clr_stb,
    input  logic [NPIN-1:0] clr_mask,
    output logic [NPIN-1:0] stat_q,
    output logic [NPIN-1:0] hit,
    output logic            irq_q
);
    logic [NPIN-1:0] prev_q;

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic now_act, was_act;
        assign now_act = lvl[p] ^ low_sel[p];
        assign was_act = prev_q[p] ^ low_sel[p];
        assign hit[p]  = edge_sel[p] ? (now_act & ~was_act) : now_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            stat_q <= (stat_q & ~(clr_stb ? clr_mask : '0)) | hit;
            irq_q  <= |(stat_q & en);
        end
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq
);
    localparam int unsigned IW = (NPIN > 1) ? $clog2(NPIN) : 1;

    wr_strobe_t      stb;
    logic [NPIN-1:0] wd, lvl_s, out_q, dir_q, mode_q, pol_q, en_q, stat_q, hit_v;
    logic [IW-1:0]   pin_sel;

    assign stb     = decode_write(bus_we, bus_addr);
    assign wd      = bus_wdata[NPIN-1:0];
    assign pin_sel = bus_addr[IW-1:0];

    gpio_in_sync #(.W(NPIN), .STAGES(SYNC_FF)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(lvl_s)
    );

    gpio_port_regs #(.NPIN(NPIN)) u_regs (
        .clk(clk), .rst(rst), .stb(stb), .wd(wd),
        .out_q(out_q), .dir_q(dir_q), .mode_q(mode_q), .pol_q(pol_q), .en_q(en_q)
    );

    gpio_pin_irq #(.NPIN(NPIN)) u_irq (
        .clk(clk), .rst(rst), .lvl(lvl_s), .edge_sel(mode_q), .low_sel(pol_q),
        .en(en_q), .clr_stb(stb.stat_clr), .clr_mask(wd),
        .stat_q(stat_q), .hit(hit_v), .irq_q(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr >= W_PIN_BASE) begin
            if (int'(pin_sel) < NPIN && int'(bus_addr - W_PIN_BASE) < NPIN)
                bus_rdata[0] = lvl_s[pin_sel];
        end else begin
            case (bus_addr)
                W_OUT_SET:  bus_rdata[NPIN-1:0] = out_q;
                W_DIR_SET:  bus_rdata[NPIN-1:0] = dir_q;
                W_PIN_WORD: bus_rdata[NPIN-1:0] = lvl_s;
                W_IRQ_MODE: bus_rdata[NPIN-1:0] = mode_q;
                W_IRQ_POL:  bus_rdata[NPIN-1:0] = pol_q;
                W_IRQ_STAT: bus_rdata[NPIN-1:0] = stat_q;
                W_IRQ_EN:   bus_rdata[NPIN-1:0] = en_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_port_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic              irq,
    input logic [NPIN-1:0]   stat_q,
    input logic [NPIN-1:0]   hit_v,
    input logic [NPIN-1:0]   en_q
);
    p_out_set_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_OUT_SET) |=> ((pad_out & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));
    p_out_clr_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_OUT_CLR) |=> ((pad_out & $past(bus_wdata[NPIN-1:0])) == '0));
    p_out_tgl_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_OUT_TGL) |=> (pad_out == ($past(pad_out) ^ $past(bus_wdata[NPIN-1:0]))));
    p_dir_set_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_DIR_SET) |=> ((pad_oe & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));
    p_dir_clr_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_DIR_CLR) |=> ((pad_oe & $past(bus_wdata[NPIN-1:0])) == '0));
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(pad_out) && $stable(pad_oe)));
    p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == W_IRQ_STAT) |=>
        ((stat_q & $past(bus_wdata[NPIN-1:0])) == ($past(hit_v) & $past(bus_wdata[NPIN-1:0]))));
    p_keep_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(stat_q) & ~($past(bus_we && bus_addr == W_IRQ_STAT) ? $past(bus_wdata[NPIN-1:0]) : '0)) & ~stat_q) == '0));
    p_irq_on_r10: assert property (@(posedge clk) disable iff (rst)
        (|(stat_q & en_q)) |=> irq);
    p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
        !(|(stat_q & en_q)) |=> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq), .stat_q(stat_q), .hit_v(hit_v), .en_q(en_q)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pin = '0;
    logic [31:0] pout, poe;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_port dut_i (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .pad_in(pin), .pad_out(pout), .pad_oe(poe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, eo, ed, pol;
        cyc(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 pad_oe", poe, 32'h0);
        chk("R1 pad_out", pout, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd(6'd8, v); chk("R1 status", v, 32'h0);
        rd(6'd6, v); chk("R1 mode", v, 32'h0);

        // R2 set/clear/toggle with arithmetic patterns, R5 readback of word 0
        eo = 32'h0;
        for (int k = 0; k < 24; k++) begin
            logic [31:0] pat;
            pat = (32'h9E37_79B9 * (k + 1)) ^ (32'h0001_0001 << (k % 16));
            wr(6'(k % 3), pat);
            case (k % 3)
                0: eo = eo | pat;
                1: eo = eo & ~pat;
                default: eo = eo ^ pat;
            endcase
            chk("R2 pad_out", pout, eo);
            rd(6'd0, v); chk("R5 latch read", v, eo);
        end

        // R3 direction set/clear, R5 readback of word 3
        ed = 32'h0;
        wr(6'd3, 32'hF0F0_1234); ed = ed | 32'hF0F0_1234;
        chk("R3 dir set", poe, ed);
        wr(6'd4, 32'h3030_0204); ed = ed & ~32'h3030_0204;
        chk("R3 dir clr", poe, ed);
        rd(6'd3, v); chk("R5 dir read", v, ed);
        wr(6'd3, 32'h0); chk("R3 zero set", poe, ed);
        wr(6'd4, 32'h0); chk("R3 zero clr", poe, ed);

        // R4 latch retention across input phase
        wr(6'd0, 32'h0000_00FF); eo = eo | 32'hFF;
        wr(6'd1, 32'h0000_FF00); eo = eo & ~32'hFF00;
        wr(6'd4, 32'hFFFF_FFFF);
        chk("R4 all inputs", poe, 32'h0);
        wr(6'd3, 32'hFFFF_FFFF);
        chk("R4 oe back", poe, 32'hFFFF_FFFF);
        chk("R4 retained level", pout, eo);

        // R6 synchronized input read, pins outputs
        pin = 32'hA5C3_0F96;
        cyc(1);
        rd(6'd5, v); chk("R6 not yet visible", v, 32'h0);
        cyc(2);
        rd(6'd5, v); chk("R6 word read", v, 32'hA5C3_0F96);
        for (int n = 0; n < 32; n++) begin
            rd(6'(32 + n), v);
            chk("R6 pin read", v, {31'b0, pin[n]});
        end
        wr(6'd4, 32'hFFFF_FFFF);
        pin = ~32'hA5C3_0F96;
        cyc(3);
        rd(6'd5, v); chk("R6 word read as input", v, ~32'hA5C3_0F96);

        // R7 edge mode sweep over all pins, alternating polarity
        pol = 32'h5555_5555;
        pin = pol;
        cyc(4);
        wr(6'd6, 32'hFFFF_FFFF);
        wr(6'd7, pol);
        wr(6'd8, 32'hFFFF_FFFF);
        cyc(2);
        rd(6'd6, v); chk("R11 mode read", v, 32'hFFFF_FFFF);
        rd(6'd7, v); chk("R11 pol read", v, pol);
        rd(6'd8, v); chk("R7 idle status", v, 32'h0);
        for (int n = 0; n < 32; n++) begin
            @(negedge clk); pin[n] = ~pin[n];
            cyc(4);
            rd(6'd8, v); chk("R7 active edge", v, 32'h1 << n);
            wr(6'd8, 32'h1 << n);
            rd(6'd8, v); chk("R9 cleared", v, 32'h0);
            cyc(2);
            rd(6'd8, v); chk("R7 single set per edge", v, 32'h0);
            @(negedge clk); pin[n] = ~pin[n];
            cyc(4);
            rd(6'd8, v); chk("R7 other edge ignored", v, 32'h0);
        end

        // R9 zero bits untouched by clear
        wr(6'd7, 32'h0);
        @(negedge clk); pin = 32'h0;
        cyc(4);
        wr(6'd8, 32'hFFFF_FFFF);
        @(negedge clk); pin = 32'h0000_0220;
        cyc(4);
        rd(6'd8, v); chk("R7 two rising edges", v, 32'h0000_0220);
        wr(6'd8, 32'h0000_0020);
        rd(6'd8, v); chk("R9 only written bit clears", v, 32'h0000_0200);

        // R8 level mode, set beats clear
        @(negedge clk); pin = 32'h0;
        cyc(4);
        wr(6'd6, 32'h0);
        wr(6'd8, 32'hFFFF_FFFF);
        rd(6'd8, v); chk("R8 idle level", v, 32'h0);
        @(negedge clk); pin = 32'h0000_0008;
        cyc(4);
        rd(6'd8, v); chk("R8 high level", v, 32'h8);
        wr(6'd8, 32'h8);
        rd(6'd8, v); chk("R9 set wins over clear", v, 32'h8);
        cyc(3);
        rd(6'd8, v); chk("R8 still set", v, 32'h8);

        // R10 enable mask and registered request
        chk("R10 masked irq", {31'b0, irq}, 32'h0);
        wr(6'd9, 32'h0000_0008);
        rd(6'd9, v); chk("R11 en read", v, 32'h8);
        cyc(1);
        chk("R10 irq raised", {31'b0, irq}, 32'h1);
        wr(6'd7, 32'h0000_0001);
        cyc(1);
        rd(6'd8, v); chk("R7 low-level polarity", v, 32'h9);
        @(negedge clk); pin = 32'h0;
        wr(6'd7, 32'h0);
        cyc(4);
        wr(6'd8, 32'hFFFF_FFFF);
        rd(6'd8, v); chk("R8 clear sticks when level gone", v, 32'h0);
        cyc(2);
        chk("R10 irq dropped", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule